// File: doc/BRIEF.md
# Event Timer with Shared Watchdog Prescaler

An 8-bit up-counting timer for a small controller. Its count source is either the instruction clock or an edge on an external input. The instruction clock is one pulse every four system clocks. The external input is resynchronised, and a control bit chooses whether rising or falling edges count. One 8-bit prescaler serves two consumers. It either divides the timer's source or divides the tick of a companion watchdog counter, and a 3-bit rate field picks the division ratio.

Every timer increment is first captured at an instruction-cycle boundary and takes effect at the following boundary. The count therefore moves only in step with the instruction clock, whatever the source. When the count wraps from 0xFF to 0x00 it sets a sticky overflow flag, and the interrupt request is that flag gated by an enable bit. Software writes an option register, a count register and an interrupt-control register through a simple strobed bus. The watchdog counts instruction cycles while enabled and emits a one-clock time-out pulse when it wraps.

Top module: `tick_timer`

## Requirements
- R1: After reset the option register reads 0xFF, and the count, the overflow flag, the enable bit, the request and the time-out output are all 0.
- R2: With option bit 5 = 0 the source is the instruction clock. With bit 3 = 1 as well, the count advances by one every four system clocks.
- R3: With option bit 5 = 1 the count source is the external input after a two-flop synchroniser. Option bit 4 = 0 counts rising edges and bit 4 = 1 counts falling edges.
- R4: With option bit 3 = 0 the prescaler divides the timer source. Rate field bits [2:0] = k gives one increment per 2^(k+1) source events.
- R5: With option bit 3 = 1 the timer takes every source event. The watchdog then takes one tick per 2^k instruction cycles, where k is bits [2:0].
- R6: An increment request is captured at the next instruction-cycle boundary. The count changes at the boundary after that.
- R7: A wrap of the count from 0xFF to 0x00 sets the flag (interrupt-control bit 0). The flag stays set until a software write clears it. A hardware set wins over a clear in the same cycle.
- R8: The request output is high exactly when the flag and the enable bit (interrupt-control bit 1) are both 1.
- R9: A count write loads the value. If the prescaler belongs to the timer, the write also clears the prescaler. In either case it drops pending requests and suppresses increments for the next two instruction-cycle boundaries.
- R10: While enabled, the watchdog counts its ticks and pulses the time-out output for one clock on each wrap of its 8-bit count. The clear input resets the count, and also resets the prescaler when the prescaler is assigned to the watchdog.
- R11: A write to the option register stores all eight bits and reads them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 1 | External count input, asynchronous |
| wdata | input | 8 | Bus write data |
| wr_opt | input | 1 | Write strobe for the option register |
| wr_cnt | input | 1 | Write strobe for the count register |
| wr_intc | input | 1 | Write strobe for the interrupt-control register |
| wdt_en | input | 1 | Watchdog enable |
| wdt_clr | input | 1 | Watchdog clear |
| opt_q | output | 8 | Option register contents |
| cnt_q | output | 8 | Count register |
| flag_q | output | 1 | Overflow flag |
| ien_q | output | 1 | Interrupt enable bit |
| irq | output | 1 | Interrupt request |
| wdt_to | output | 1 | Watchdog time-out pulse |

## Verification
The timer is driven first from the undivided instruction clock. It is then driven through every kind of prescaler rate (minimum, middle and maximum), which separates a wrong tap choice from a wrong ratio. The external input is toggled slowly, first with the rising edge selected and then with the falling edge, so a swapped edge polarity or a missing synchroniser stage shows as a phase shift against the model. Count writes land both mid-prescale and near wrap, which exposes a missed prescaler clear, a wrong hold length and a lost overflow. The watchdog runs once with the prescaler and once without, so the ratio rule for each owner is checked separately.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int RATE_W = 3;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [1:0]        spare;
    logic              src_ext;
    logic              edge_fall;
    logic              pre_to_wdt;
    logic [RATE_W-1:0] rate;
  } opt_t;

  localparam logic [DATA_W-1:0] OPT_RST = '1;
  localparam int FLAG_BIT = 0;
  localparam int IEN_BIT  = 1;
endpackage

// File: rtl/tick_src_sel.sv
module tick_src_sel #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  input  logic edge_fall,
  input  logic src_ext,
  output logic icyc,
  output logic src_evt
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PH_W-1:0] phase;
  logic            s1, s2, lev_prev;
  logic            lev, edge_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      s1       <= 1'b0;
      s2       <= 1'b0;
      lev_prev <= 1'b0;
    end else begin
      phase    <= (phase == PH_W'(DIV - 1)) ? '0 : phase + 1'b1;
      s1       <= ext_in;
      s2       <= s1;
      lev_prev <= lev;
    end
  end

  assign icyc     = (phase == PH_W'(DIV - 1));
  assign lev      = s2 ^ edge_fall;
  assign edge_evt = lev & ~lev_prev;
  assign src_evt  = src_ext ? edge_evt : icyc;
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_evt,
  input  logic              clr,
  input  logic [RATE_W-1:0] rate,
  output logic              tmr_out,
  output logic              wdt_out
);
  localparam int NTAP = 1 << RATE_W;

  logic [NTAP-1:0] pcnt;
  logic [NTAP-1:0] tmr_tap, wdt_tap;

  always_ff @(posedge clk) begin
    if (rst || clr)  pcnt <= '0;
    else if (in_evt) pcnt <= pcnt + 1'b1;
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tmr_tap[k] = in_evt & (&pcnt[k:0]);
    if (k == 0) begin : g_first
      assign wdt_tap[k] = in_evt;
    end else begin : g_rest
      assign wdt_tap[k] = in_evt & (&pcnt[k-1:0]);
    end
  end

  assign tmr_out = tmr_tap[rate];
  assign wdt_out = wdt_tap[rate];
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 8,
  parameter int HOLD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             icyc,
  input  logic             inc_evt,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             hold_busy
);
  localparam int HOLD_W = $clog2(HOLD + 1);

  logic              pend, sy;
  logic [HOLD_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
      sy   <= 1'b0;
      hold <= '0;
    end else if (wr) begin
      cnt  <= wdata;
      pend <= 1'b0;
      sy   <= 1'b0;
      hold <= HOLD_W'(HOLD);
    end else if (icyc) begin
      if (hold != '0)  hold <= hold - 1'b1;
      else if (sy)     cnt  <= cnt + 1'b1;
      sy   <= pend | inc_evt;
      pend <= 1'b0;
    end else begin
      pend <= pend | inc_evt;
    end
  end

  assign hold_busy = (hold != '0);
  assign ovf = ~wr & icyc & ~hold_busy & sy & (&cnt);
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic evt,
  input  logic clr,
  output logic to
);
  logic [WDT_W-1:0] wc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wc <= '0;
      to <= 1'b0;
    end else begin
      to <= 1'b0;
      if (en && evt) begin
        wc <= wc + 1'b1;
        to <= &wc;
      end
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int WDT_W = 8,
  parameter int HOLD  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_in,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_opt,
  input  logic              wr_cnt,
  input  logic              wr_intc,
  input  logic              wdt_en,
  input  logic              wdt_clr,
  output logic [DATA_W-1:0] opt_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              flag_q,
  output logic              ien_q,
  output logic              irq,
  output logic              wdt_to
);
  opt_t opt;
  logic icyc, src_evt, pre_in, pre_clr, pre_tmr, pre_wdt;
  logic tmr_evt, wdt_base, wdt_evt, ovf, hold_busy;

  assign opt = opt_t'(opt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q  <= OPT_RST;
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_opt) opt_q <= wdata;
      if (ovf)          flag_q <= 1'b1;
      else if (wr_intc) flag_q <= wdata[FLAG_BIT];
      if (wr_intc) ien_q <= wdata[IEN_BIT];
    end
  end

  tick_src_sel #(.DIV(DIV)) u_src (
    .clk(clk), .rst(rst), .ext_in(ext_in), .edge_fall(opt.edge_fall),
    .src_ext(opt.src_ext), .icyc(icyc), .src_evt(src_evt)
  );

  assign wdt_base = icyc & wdt_en;
  assign pre_in   = opt.pre_to_wdt ? wdt_base : src_evt;
  assign pre_clr  = opt.pre_to_wdt ? wdt_clr : wr_cnt;

  tick_prescaler #(.RATE_W(RATE_W)) u_pre (
    .clk(clk), .rst(rst), .in_evt(pre_in), .clr(pre_clr), .rate(opt.rate),
    .tmr_out(pre_tmr), .wdt_out(pre_wdt)
  );

  assign tmr_evt = opt.pre_to_wdt ? src_evt : pre_tmr;
  assign wdt_evt = opt.pre_to_wdt ? pre_wdt : wdt_base;

  tick_counter #(.CNT_W(DATA_W), .HOLD(HOLD)) u_cnt (
    .clk(clk), .rst(rst), .icyc(icyc), .inc_evt(tmr_evt), .wr(wr_cnt),
    .wdata(wdata), .cnt(cnt_q), .ovf(ovf), .hold_busy(hold_busy)
  );

  tick_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk(clk), .rst(rst), .en(wdt_en), .evt(wdt_evt), .clr(wdt_clr), .to(wdt_to)
  );

  assign irq = flag_q & ien_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] wdata,
  input logic       wr_cnt,
  input logic       wr_intc,
  input logic [7:0] opt_q,
  input logic [7:0] cnt_q,
  input logic       flag_q,
  input logic       wdt_to,
  input logic       hold_busy
);
  // R1
  reset_opt_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> opt_q == 8'hFF);

  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q && !wr_intc |=> flag_q);

  // R7
  rose_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) && !$past(wr_intc) |-> $past(cnt_q) == 8'hFF && cnt_q == 8'h00);

  // R9
  load_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> cnt_q == $past(wdata));

  // R9
  hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    hold_busy && !wr_cnt |=> $stable(cnt_q));

  // R6
  step_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 8'd1));

  // R10
  wdt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_to |=> !wdt_to);
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk(clk), .rst(rst), .wdata(wdata), .wr_cnt(wr_cnt), .wr_intc(wr_intc),
  .opt_q(opt_q), .cnt_q(cnt_q), .flag_q(flag_q), .wdt_to(wdt_to),
  .hold_busy(hold_busy)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_in = 1'b0;
  logic [7:0] wdata = '0;
  logic       wr_opt = 1'b0, wr_cnt = 1'b0, wr_intc = 1'b0;
  logic       wdt_en = 1'b0, wdt_clr = 1'b0;
  logic [7:0] opt_q, cnt_q;
  logic       flag_q, ien_q, irq, wdt_to;

  int n_chk = 0, n_bad = 0, n_to = 0;
  string cur_req = "R1";
  bit live = 1'b0;

  always #10 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst(rst), .ext_in(ext_in), .wdata(wdata), .wr_opt(wr_opt),
    .wr_cnt(wr_cnt), .wr_intc(wr_intc), .wdt_en(wdt_en), .wdt_clr(wdt_clr),
    .opt_q(opt_q), .cnt_q(cnt_q), .flag_q(flag_q), .ien_q(ien_q),
    .irq(irq), .wdt_to(wdt_to)
  );

  // reference model state
  int m_ph, m_s1, m_s2, m_lp, m_pv, m_cnt, m_pend, m_sy, m_hold, m_wc;
  int m_opt, m_flag, m_ien, m_to;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_s1 = 0; m_s2 = 0; m_lp = 0; m_pv = 0; m_cnt = 0;
      m_pend = 0; m_sy = 0; m_hold = 0; m_wc = 0; m_opt = 255;
      m_flag = 0; m_ien = 0; m_to = 0;
    end else begin
      int rate, src, efall, psa, ic, lev, edg, sev, pin, mt, mw, tev, wev, ovf, clr;
      rate = m_opt % 8; psa = (m_opt >> 3) & 1;
      efall = (m_opt >> 4) & 1; src = (m_opt >> 5) & 1;
      ic = (m_ph == 3);
      lev = m_s2 ^ efall; edg = lev & (m_lp == 0);
      sev = src ? edg : ic;
      pin = psa ? (ic & wdt_en) : sev;
      mt = (1 << (rate + 1)) - 1; mw = (1 << rate) - 1;
      tev = psa ? sev : (pin && ((m_pv & mt) == mt));
      wev = psa ? (pin && ((m_pv & mw) == mw)) : (ic & wdt_en);
      clr = psa ? wdt_clr : wr_cnt;
      ovf = 0;
      // prescaler
      if (clr) m_pv = 0; else if (pin) m_pv = (m_pv + 1) % 256;
      // count path
      if (wr_cnt) begin
        m_cnt = wdata; m_pend = 0; m_sy = 0; m_hold = 2;
      end else if (ic) begin
        if (m_hold > 0) m_hold--;
        else if (m_sy) begin
          if (m_cnt == 255) ovf = 1;
          m_cnt = (m_cnt + 1) % 256;
        end
        m_sy = m_pend | tev; m_pend = 0;
      end else m_pend = m_pend | tev;
      if (ovf) m_flag = 1; else if (wr_intc) m_flag = wdata[0];
      if (wr_intc) m_ien = wdata[1];
      // watchdog
      if (wdt_clr) begin m_wc = 0; m_to = 0; end
      else begin
        m_to = 0;
        if (wdt_en && wev) begin m_to = (m_wc == 255); m_wc = (m_wc + 1) % 256; end
      end
      if (wr_opt) m_opt = wdata;
      m_lp = lev; m_s2 = m_s1; m_s1 = ext_in;
      m_ph = (m_ph + 1) % 4;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !rst) begin
      check(cur_req, "cnt_q", cnt_q, m_cnt);
      check(cur_req, "flag_q", flag_q, m_flag);
      check(cur_req, "ien_q", ien_q, m_ien);
      check("R8", "irq", irq, m_flag & m_ien);
      check(cur_req, "wdt_to", wdt_to, m_to);
      check("R11", "opt_q", opt_q, m_opt);
      if (wdt_to) n_to++;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int which, logic [7:0] d);
    @(negedge clk);
    wdata = d;
    wr_opt = (which == 0); wr_cnt = (which == 1); wr_intc = (which == 2);
    @(negedge clk);
    wr_opt = 1'b0; wr_cnt = 1'b0; wr_intc = 1'b0;
  endtask

  task automatic toggle_ext(int n, int gap);
    for (int i = 0; i < n; i++) begin
      run(gap);
      ext_in = ~ext_in;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "opt_q", opt_q, 8'hFF);
    check("R1", "cnt_q", cnt_q, 0);
    check("R1", "flag_q", flag_q, 0);
    check("R1", "irq", irq, 0);
    check("R1", "wdt_to", wdt_to, 0);
    live = 1'b1;
    // R11 option write, then R2 and R6 internal undivided
    cur_req = "R2 R6";
    wr(0, 8'hC8);
    check("R11", "opt readback", opt_q, 8'hC8);
    run(200);
    // R9 load near wrap, R7 and R8 overflow with enable
    cur_req = "R9 R7";
    wr(2, 8'h02);
    wr(1, 8'hF0);
    run(120);
    check("R7", "flag after wrap", flag_q, 1);
    check("R8", "irq after wrap", irq, 1);
    wr(2, 8'h02);
    check("R7", "flag cleared", flag_q, 0);
    check("R8", "irq cleared", irq, 0);
    // R4 prescaler on timer at several rates
    cur_req = "R4";
    wr(0, 8'hC2); run(500);
    wr(0, 8'hC0); run(100);
    wr(0, 8'hC7); run(300);
    // R9 write mid-prescale clears prescaler
    cur_req = "R9";
    wr(0, 8'hC1); run(30);
    wr(1, 8'h55); run(60);
    wr(1, 8'hFE); run(80);
    // R3 external edges, rising then falling, then prescaled
    cur_req = "R3";
    wr(0, 8'hE8); toggle_ext(40, 5);
    wr(0, 8'hF8); toggle_ext(40, 7);
    wr(0, 8'hE1); toggle_ext(40, 6);
    // R5 and R10 watchdog with and without prescaler
    cur_req = "R5 R10";
    wr(0, 8'hC9);
    wdt_en = 1'b1;
    run(2200);
    check("R10", "timeouts with prescaler", (n_to >= 1) ? 1 : 0, 1);
    @(negedge clk); wdt_clr = 1'b1;
    @(negedge clk); wdt_clr = 1'b0;
    run(300);
    wr(0, 8'hC0);
    n_to = 0;
    run(1200);
    check("R10", "timeouts undivided", (n_to >= 1) ? 1 : 0, 1);
    live = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule